// File: doc/BRIEF.md
# Belt Operand Rename Unit

This unit sits beside one execution unit in a machine where instructions name their operands by distance along a moving result queue rather than by register number. A source written as bN means "the value produced N results ago", so b1 is the newest result. The unit keeps a running count of results allocated in program order. When a result-producing operation is decoded, the unit gives it the next slot of a circular pool. Each distance reference is turned into an absolute pool slot, using the count as it stood before the current operation.

Because every slot is fixed at decode, results may complete in any order and are written straight to their slot. Each slot has a valid bit that tells the issue logic whether an operand is ready. Each slot also has a small generation tag that a completion must carry. Named checkpoints record the allocation count at a branch. A restore winds the count back and invalidates every slot allocated since the checkpoint, so that late completions from the wrong path are dropped.

Top module: `belt_rename_unit`

## Requirements
- R1: After reset, dec_ready is 1, the first destination slot is 0, every source reads as not ready, and b1 resolves to slot 31.
- R2: An accepted decode with dec_produces=1 takes slot (count mod 32) and then advances the count by one. A decode with dec_produces=0 does not advance the count.
- R3: A source distance N resolves to slot (count − N) mod 32. The count used is the one before this cycle's own allocation, so an operation never sees its own result.
- R4: A source is ready exactly when its slot holds a completed value. An accepted completion makes the slot ready from the next cycle on, and allocating a slot makes it not ready again.
- R5: Completions may arrive in any order. Each lands in its own slot, and its data is returned on srcX_data for the matching distance.
- R6: A distance of 0 or above 32 raises srcX_err and reads as not ready, even if the wrapped slot is valid. A distance of 32 is legal.
- R7: When 32 results are in flight (allocated and not yet retired), dec_ready is 0 and a decode does not allocate. A ret_valid pulse retires the oldest result and reopens decode.
- R8: chk_save stores the pre-allocation count under chk_save_id. chk_restore reloads the count saved under chk_restore_id, so the next allocation reuses the first slot taken after the checkpoint.
- R9: A restore invalidates every slot allocated after the checkpoint, whether or not it had completed. Slots allocated before the checkpoint keep their valid bit and data.
- R10: dec_dst_gen gives the generation tag of the slot being allocated. The tag advances by one on each allocation and on each invalidation by restore. A completion whose cmp_gen does not match the slot's current tag is dropped.
- R11: In a cycle with chk_restore=1, dec_ready is 0 and a decode in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An operation is presented at decode |
| dec_produces | input | 1 | The presented operation writes a result |
| dec_src0_dist | input | 6 | Distance N of source 0 |
| dec_src1_dist | input | 6 | Distance N of source 1 |
| dec_ready | output | 1 | Decode can accept this cycle |
| dec_dst_slot | output | 5 | Slot given to the next result |
| dec_dst_gen | output | 2 | Generation tag the allocated slot will carry |
| src0_slot | output | 5 | Resolved slot of source 0 |
| src0_ready | output | 1 | Source 0 value is available |
| src0_err | output | 1 | Source 0 distance is illegal |
| src0_data | output | 32 | Source 0 value |
| src1_slot | output | 5 | Resolved slot of source 1 |
| src1_ready | output | 1 | Source 1 value is available |
| src1_err | output | 1 | Source 1 distance is illegal |
| src1_data | output | 32 | Source 1 value |
| cmp_valid | input | 1 | A result completes |
| cmp_slot | input | 5 | Slot of the completing result |
| cmp_gen | input | 2 | Generation tag carried by the completion |
| cmp_data | input | 32 | Result value |
| ret_valid | input | 1 | Retire the oldest in-flight result |
| chk_save | input | 1 | Record a checkpoint |
| chk_save_id | input | 2 | Checkpoint entry to record |
| chk_restore | input | 1 | Roll back to a checkpoint |
| chk_restore_id | input | 2 | Checkpoint entry to roll back to |

## Verification
The hardest state to reach is a slot that completed on the wrong path, was invalidated by a restore, and was then allocated again, while a stale completion carrying its old tag is still arriving. The stimulus builds this directly. It fills slots, saves a checkpoint, allocates and completes past it, restores, allocates the same slots again, and then drives a completion with the old tag before one with the new tag. Pool wrap and the full stall are reached by allocating 32 results with no retire, so a stalled decode and the reuse of slot 0 are both observed at the ports.

// File: rtl/belt_pkg.sv
package belt_pkg;
  localparam int DEPTH  = 32;
  localparam int GEN_W  = 2;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SEQ_W  = IDX_W + 1;
  localparam int DIST_W = IDX_W + 1;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [DIST_W-1:0] dist_t;
  typedef logic [GEN_W-1:0]  gen_t;
  typedef logic [DATA_W-1:0] data_t;

  // slot reached by walking n results back from allocation count s
  function automatic idx_t ref_slot(seq_t s, dist_t n);
    seq_t back;
    back = s - seq_t'(n);
    return back[IDX_W-1:0];
  endfunction

  // distance outside 1..DEPTH
  function automatic logic ref_bad(dist_t n);
    return (n == '0) || (int'(n) > DEPTH);
  endfunction

  // number of allocations from older to newer
  function automatic seq_t span(seq_t newer, seq_t older);
    return newer - older;
  endfunction

  // slot lies in the cnt allocations starting at base
  function automatic logic in_span(idx_t slot, seq_t base, seq_t cnt);
    idx_t off;
    off = slot - base[IDX_W-1:0];
    return {1'b0, off} < cnt;
  endfunction
endpackage

// File: rtl/belt_seq_ctrl.sv
module belt_seq_ctrl
  import belt_pkg::*;
#(
  parameter int NUM_CHK = 4,
  localparam int CHK_W  = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             save_i,
  input  logic [CHK_W-1:0] save_id_i,
  input  logic             restore_i,
  input  logic [CHK_W-1:0] restore_id_i,
  output seq_t             seq_o,
  output seq_t             in_flight_o,
  output logic             restore_fire_o,
  output seq_t             kill_base_o,
  output seq_t             kill_cnt_o
);
  seq_t seq_q;
  seq_t ret_q;
  seq_t chk_q [NUM_CHK];
  logic retire_fire;

  assign seq_o          = seq_q;
  assign in_flight_o    = span(seq_q, ret_q);
  assign restore_fire_o = restore_i;
  assign kill_base_o    = chk_q[restore_id_i];
  assign kill_cnt_o     = span(seq_q, kill_base_o);
  assign retire_fire    = retire_i && (seq_q != ret_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      ret_q <= '0;
      for (int i = 0; i < NUM_CHK; i++) chk_q[i] <= '0;
    end else begin
      if (restore_i)    seq_q <= kill_base_o;
      else if (alloc_i) seq_q <= seq_q + 1'b1;
      if (retire_fire)  ret_q <= ret_q + 1'b1;
      if (save_i && !restore_i) chk_q[save_id_i] <= seq_q;
    end
  end
endmodule

// File: rtl/belt_slot_array.sv
module belt_slot_array
  import belt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  idx_t             alloc_slot_i,
  input  logic             kill_i,
  input  seq_t             kill_base_i,
  input  seq_t             kill_cnt_i,
  input  logic             cmp_valid_i,
  input  idx_t             cmp_slot_i,
  input  gen_t             cmp_gen_i,
  input  data_t            cmp_data_i,
  output logic [DEPTH-1:0] valid_o,
  output gen_t             gen_o  [DEPTH],
  output data_t            data_o [DEPTH],
  output logic             cmp_accept_o
);
  logic [DEPTH-1:0] wr_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic  kill_g, alloc_g;
    logic  valid_q;
    gen_t  gen_q;
    data_t data_q;

    assign kill_g    = kill_i && in_span(idx_t'(g), kill_base_i, kill_cnt_i);
    assign alloc_g   = alloc_i && (alloc_slot_i == idx_t'(g));
    assign wr_vec[g] = cmp_valid_i && (cmp_slot_i == idx_t'(g)) &&
                       (cmp_gen_i == gen_q) && !kill_g && !alloc_g;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        gen_q   <= '0;
        data_q  <= '0;
      end else if (kill_g || alloc_g) begin
        valid_q <= 1'b0;
        gen_q   <= gen_q + 1'b1;
      end else if (wr_vec[g]) begin
        valid_q <= 1'b1;
        data_q  <= cmp_data_i;
      end
    end

    assign valid_o[g] = valid_q;
    assign gen_o[g]   = gen_q;
    assign data_o[g]  = data_q;
  end

  assign cmp_accept_o = |wr_vec;
endmodule

// File: rtl/belt_src_lookup.sv
module belt_src_lookup
  import belt_pkg::*;
(
  input  seq_t             seq_i,
  input  dist_t            dist_i,
  input  logic [DEPTH-1:0] valid_i,
  input  data_t            data_i [DEPTH],
  output idx_t             slot_o,
  output logic             ready_o,
  output logic             err_o,
  output data_t            data_o
);
  assign slot_o  = ref_slot(seq_i, dist_i);
  assign err_o   = ref_bad(dist_i);
  assign ready_o = valid_i[slot_o] && !err_o;
  assign data_o  = data_i[slot_o];
endmodule

// File: rtl/belt_rename_unit.sv
module belt_rename_unit
  import belt_pkg::*;
#(
  parameter int NUM_CHK = 4,
  localparam int CHK_W  = (NUM_CHK > 1) ? $clog2(NUM_CHK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic              dec_produces,
  input  logic [DIST_W-1:0] dec_src0_dist,
  input  logic [DIST_W-1:0] dec_src1_dist,
  output logic              dec_ready,
  output logic [IDX_W-1:0]  dec_dst_slot,
  output logic [GEN_W-1:0]  dec_dst_gen,
  output logic [IDX_W-1:0]  src0_slot,
  output logic              src0_ready,
  output logic              src0_err,
  output logic [DATA_W-1:0] src0_data,
  output logic [IDX_W-1:0]  src1_slot,
  output logic              src1_ready,
  output logic              src1_err,
  output logic [DATA_W-1:0] src1_data,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_slot,
  input  logic [GEN_W-1:0]  cmp_gen,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              ret_valid,
  input  logic              chk_save,
  input  logic [CHK_W-1:0]  chk_save_id,
  input  logic              chk_restore,
  input  logic [CHK_W-1:0]  chk_restore_id
);
  seq_t             seq;
  seq_t             in_flight;
  logic             pool_full;
  logic             alloc_fire;
  logic             restore_fire;
  seq_t             kill_base;
  seq_t             kill_cnt;
  logic             cmp_accept;
  logic [DEPTH-1:0] valid_vec;
  gen_t             gen_arr  [DEPTH];
  data_t            data_arr [DEPTH];

  assign pool_full    = (in_flight == seq_t'(DEPTH));
  assign dec_ready    = !pool_full && !chk_restore;
  assign alloc_fire   = dec_valid && dec_ready && dec_produces;
  assign dec_dst_slot = seq[IDX_W-1:0];
  assign dec_dst_gen  = gen_arr[dec_dst_slot] + 1'b1;

  belt_seq_ctrl #(.NUM_CHK(NUM_CHK)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_i        (alloc_fire),
    .retire_i       (ret_valid),
    .save_i         (chk_save),
    .save_id_i      (chk_save_id),
    .restore_i      (chk_restore),
    .restore_id_i   (chk_restore_id),
    .seq_o          (seq),
    .in_flight_o    (in_flight),
    .restore_fire_o (restore_fire),
    .kill_base_o    (kill_base),
    .kill_cnt_o     (kill_cnt)
  );

  belt_slot_array u_slots (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_i      (alloc_fire),
    .alloc_slot_i (dec_dst_slot),
    .kill_i       (restore_fire),
    .kill_base_i  (kill_base),
    .kill_cnt_i   (kill_cnt),
    .cmp_valid_i  (cmp_valid),
    .cmp_slot_i   (cmp_slot),
    .cmp_gen_i    (cmp_gen),
    .cmp_data_i   (cmp_data),
    .valid_o      (valid_vec),
    .gen_o        (gen_arr),
    .data_o       (data_arr),
    .cmp_accept_o (cmp_accept)
  );

  belt_src_lookup u_src0 (
    .seq_i   (seq),
    .dist_i  (dec_src0_dist),
    .valid_i (valid_vec),
    .data_i  (data_arr),
    .slot_o  (src0_slot),
    .ready_o (src0_ready),
    .err_o   (src0_err),
    .data_o  (src0_data)
  );

  belt_src_lookup u_src1 (
    .seq_i   (seq),
    .dist_i  (dec_src1_dist),
    .valid_i (valid_vec),
    .data_i  (data_arr),
    .slot_o  (src1_slot),
    .ready_o (src1_ready),
    .err_o   (src1_err),
    .data_o  (src1_data)
  );
endmodule

// File: rtl/belt_rename_checker.sv
module belt_rename_checker
  import belt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input seq_t             seq,
  input seq_t             in_flight,
  input logic             alloc_fire,
  input logic             restore_fire,
  input seq_t             kill_base,
  input logic             cmp_accept,
  input idx_t             cmp_slot,
  input idx_t             dst_slot,
  input logic [DEPTH-1:0] valid_vec,
  input logic             dec_ready,
  input logic             src0_err,
  input logic             src0_ready,
  input logic             src1_err,
  input logic             src1_ready
);
  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (seq == seq_t'($past(seq) + 1'b1)));

  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_accept |=> valid_vec[$past(cmp_slot)]);

  assert_clear_on_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !valid_vec[$past(dst_slot)]);

  assert_err_src0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src0_err |-> !src0_ready);

  assert_err_src1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src1_err |-> !src1_ready);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_flight) <= DEPTH);

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(in_flight) == DEPTH) |-> !dec_ready);

  assert_restore_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_fire |=> (seq == $past(kill_base)));
endmodule

bind belt_rename_unit belt_rename_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seq          (seq),
  .in_flight    (in_flight),
  .alloc_fire   (alloc_fire),
  .restore_fire (restore_fire),
  .kill_base    (kill_base),
  .cmp_accept   (cmp_accept),
  .cmp_slot     (cmp_slot),
  .dst_slot     (dec_dst_slot),
  .valid_vec    (valid_vec),
  .dec_ready    (dec_ready),
  .src0_err     (src0_err),
  .src0_ready   (src0_ready),
  .src1_err     (src1_err),
  .src1_ready   (src1_ready)
);

// File: tb/tb_belt_rename_unit.sv
module tb_belt_rename_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_produces;
  logic [5:0]  dec_src0_dist, dec_src1_dist;
  logic        dec_ready;
  logic [4:0]  dec_dst_slot;
  logic [1:0]  dec_dst_gen;
  logic [4:0]  src0_slot, src1_slot;
  logic        src0_ready, src0_err, src1_ready, src1_err;
  logic [31:0] src0_data, src1_data;
  logic        cmp_valid;
  logic [4:0]  cmp_slot;
  logic [1:0]  cmp_gen;
  logic [31:0] cmp_data;
  logic        ret_valid, chk_save, chk_restore;
  logic [1:0]  chk_save_id, chk_restore_id;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  belt_rename_unit dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap_slot(input int s, input int n);
    return ((s - n) % 32 + 32) % 32;
  endfunction

  task automatic idle();
    dec_valid = 0; dec_produces = 0; dec_src0_dist = 0; dec_src1_dist = 0;
    cmp_valid = 0; cmp_slot = 0; cmp_gen = 0; cmp_data = 0;
    ret_valid = 0; chk_save = 0; chk_restore = 0; chk_save_id = 0; chk_restore_id = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
    step();
  endtask

  task automatic issue(input bit prod);
    dec_valid = 1; dec_produces = prod;
    step();
    dec_valid = 0; dec_produces = 0;
  endtask

  task automatic complete(input int slot, input int gen, input int data);
    cmp_valid = 1; cmp_slot = 5'(slot); cmp_gen = 2'(gen); cmp_data = data;
    step();
    cmp_valid = 0;
  endtask

  task automatic look(input int n0, input int n1);
    dec_src0_dist = 6'(n0); dec_src1_dist = 6'(n1);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    look(1, 2);
    check("R1", "dec_ready", dec_ready, 1);
    check("R1", "first dst slot", dec_dst_slot, 0);
    check("R1", "b1 slot", src0_slot, 31);
    check("R1", "b1 ready", src0_ready, 0);
    check("R1", "b2 ready", src1_ready, 0);
  endtask

  task automatic t_alloc();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      #1 check("R2", "dst slot in order", dec_dst_slot, k);
      issue(1);
    end
    issue(0);
    #1 check("R2", "non-producing op keeps count", dec_dst_slot, 3);
    look(1, 3);
    check("R3", "b1 slot", src0_slot, wrap_slot(3, 1));
    check("R3", "b3 slot", src1_slot, wrap_slot(3, 3));
    look(5, 1);
    check("R3", "b5 wraps", src0_slot, wrap_slot(3, 5));
    dec_valid = 1; dec_produces = 1;
    look(1, 2);
    check("R3", "own result not counted", src0_slot, 2);
    dec_valid = 0; dec_produces = 0;
  endtask

  task automatic t_ooo();
    do_reset();
    #1 check("R10", "first tag", dec_dst_gen, 1);
    for (int k = 0; k < 3; k++) issue(1);
    // slot 0: older op (stalled), slot 1: younger op completes first
    cmp_valid = 1; cmp_slot = 1; cmp_gen = 1; cmp_data = 32'hB0B;
    look(2, 3);
    check("R4", "not ready before edge", src0_ready, 0);
    step();
    cmp_valid = 0;
    look(2, 3);
    check("R5", "younger ready first", src0_ready, 1);
    check("R5", "younger data", src0_data, 32'hB0B);
    check("R4", "older still pending", src1_ready, 0);
    complete(0, 1, 32'hA0A);
    look(3, 1);
    check("R5", "older ready", src0_ready, 1);
    check("R5", "older data", src0_data, 32'hA0A);
    check("R4", "b1 never completed", src1_ready, 0);
  endtask

  task automatic t_err();
    do_reset();
    issue(1);
    complete(0, 1, 7);
    look(1, 0);
    check("R6", "b1 ready", src0_ready, 1);
    check("R6", "b0 err", src1_err, 1);
    check("R6", "b0 not ready", src1_ready, 0);
    look(33, 63);
    check("R6", "b33 err", src0_err, 1);
    check("R6", "b33 not ready though slot valid", src0_ready, 0);
    check("R6", "b63 err", src1_err, 1);
    look(32, 1);
    check("R6", "b32 legal", src0_err, 0);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 32; k++) issue(1);
    #1 check("R7", "stall at 32", dec_ready, 0);
    issue(1);
    look(1, 0);
    check("R7", "stalled decode no alloc", dec_dst_slot, 0);
    check("R7", "count unchanged", src0_slot, 31);
    complete(0, 1, 5);
    ret_valid = 1;
    step();
    ret_valid = 0;
    #1 check("R7", "retire reopens", dec_ready, 1);
    issue(1);
    look(1, 0);
    check("R7", "stall again", dec_ready, 0);
    check("R4", "realloc clears ready", src0_ready, 0);
    check("R2", "wrap to slot 1", dec_dst_slot, 1);
  endtask

  task automatic t_ckpt();
    do_reset();
    issue(1); issue(1);
    complete(0, 1, 32'h10);
    complete(1, 1, 32'h11);
    chk_save = 1; chk_save_id = 2;
    step();
    chk_save = 0;
    issue(1); issue(1); issue(1);
    complete(3, 1, 32'h33);
    look(2, 1);
    check("R9", "wrong path slot ready", src0_ready, 1);
    chk_restore = 1; chk_restore_id = 2; dec_valid = 1; dec_produces = 1;
    #1 check("R11", "dec_ready low on restore", dec_ready, 0);
    step();
    chk_restore = 0; dec_valid = 0; dec_produces = 0;
    look(1, 2);
    check("R8", "count restored", dec_dst_slot, 2);
    check("R9", "pre-checkpoint kept", src0_ready, 1);
    check("R9", "pre-checkpoint data", src0_data, 32'h11);
    check("R9", "older kept", src1_ready, 1);
    check("R10", "tag after kill and alloc", dec_dst_gen, 3);
    issue(1); issue(1);
    look(1, 2);
    check("R9", "killed slot not ready", src0_ready, 0);
    complete(3, 1, 32'h99);
    look(1, 2);
    check("R10", "stale completion dropped", src0_ready, 0);
    complete(3, 3, 32'h44);
    look(1, 2);
    check("R10", "fresh completion ready", src0_ready, 1);
    check("R10", "fresh data", src0_data, 32'h44);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_alloc();
    t_ooo();
    t_err();
    t_full();
    t_ckpt();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule